// File: doc/BRIEF.md
# IDE strobe timing generator

This block times the read and write strobes of one parallel ATA channel for programmed-I/O and multiword DMA cycles. Each attached device owns a 32-bit timing word. The word sets the number of bus clocks the strobe stays low and high. It does this separately for data-port cycles and for task-file (command block) register cycles. It also sets a setup delay that is inserted only ahead of the first cycle of a transfer.

A request names the device, the direction (read or write), whether the cycle is a data or a command access, and whether it opens a transfer. The generator pulls the matching active-low strobe down for the active time and then holds it high for the recovery time. It marks the end of recovery with a one-clock done pulse.

Timing words are written through a load port and can be read back through a select port. A word written while a cycle is running is parked and committed once the generator is idle again. Bits that this block does not act on are stored unchanged: the ultra-DMA cycle code, the DMA enable, the bus-master-in-PIO bit and the FIFO enable. Setting the ultra-DMA enable bit in a word stops this block from running data cycles for that device.

Top module: `ide_strobe_timer`

## Requirements
- R1: After reset both strobes are high, done is low and every stored timing word reads back as zero.
- R2: For a data cycle the selected strobe is low for (word[8:4] + 1) clocks.
- R3: For a data cycle, done is asserted (word[3:0] + 1) clocks after the strobe returns high. Without setup, done is high in the clock that comes act+inact+2 clocks after the accepting edge.
- R4: For a command cycle (req_cmd = 1) the strobe is low for (word[17:13] + 1) clocks, and the recovery is (word[12:9] + 1) clocks.
- R5: A data cycle with req_first = 1 delays strobe assertion by word[24:22] clocks. With req_first = 0 there is no delay.
- R6: A command cycle with req_first = 1 delays strobe assertion by word[27:25] clocks.
- R7: Only the strobe chosen by req_write (1 = write strobe, 0 = read strobe) goes low, and the two strobes are never low together.
- R8: cycle_done is high for exactly one clock per cycle, and only after the strobe is back high.
- R9: All 32 bits of a loaded word, including the ultra-DMA code in bits 21:18 and the control bits 31:28, read back on cfg_word one clock after cfg_sel selects the device.
- R10: A word loaded while a cycle runs does not affect that cycle and does not show on readback until the generator is idle. The next cycle uses the new word.
- R11: A data request to a device whose word has bit 28 set produces no strobe and no done. A command request to that device still runs.
- R12: A request that arrives while a cycle is in progress is ignored.
- R13: Each device's word is kept and applied independently of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write a timing word |
| load_dev | input | DEV_W | Device whose word is written |
| load_word | input | 32 | Timing word value |
| cfg_sel | input | DEV_W | Device whose word is read back |
| cfg_word | output | 32 | Registered readback of the selected word |
| req_valid | input | 1 | Start a bus cycle (taken only when idle) |
| req_dev | input | DEV_W | Device the cycle addresses |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_cmd | input | 1 | 1 = task-file register access, 0 = data access |
| req_first | input | 1 | 1 = first cycle of a transfer (apply setup delay) |
| rd_strobe_n | output | 1 | Active-low read strobe |
| wr_strobe_n | output | 1 | Active-low write strobe |
| cycle_done | output | 1 | One-clock pulse at end of recovery |

## Verification
The assertions assume that reset is held for at least one clock before any request. They also assume that the device indices presented on load_dev, req_dev and cfg_sel are below the configured device count. The stimulus starts only after a reset of several clocks and uses device numbers 0 to 3 with the default of four devices. The load and request inputs are driven on the falling clock edge, so each is seen stable at exactly one rising edge. Deliberately overlapping requests and loads are issued only to check the ignore and deferral rules.

// File: rtl/ide_tmg_pkg.sv
package ide_tmg_pkg;

  localparam int WORD_W = 32;

  // field positions inside a timing word
  localparam int D_INACT_LO = 0;
  localparam int D_INACT_HI = 3;
  localparam int D_ACT_LO   = 4;
  localparam int D_ACT_HI   = 8;
  localparam int C_INACT_LO = 9;
  localparam int C_INACT_HI = 12;
  localparam int C_ACT_LO   = 13;
  localparam int C_ACT_HI   = 17;
  localparam int D_PRE_LO   = 22;
  localparam int D_PRE_HI   = 24;
  localparam int C_PRE_LO   = 25;
  localparam int C_PRE_HI   = 27;
  localparam int UDMA_EN_BIT = 28;

  localparam int ACT_W = D_ACT_HI - D_ACT_LO + 1;
  localparam int INACT_W = D_INACT_HI - D_INACT_LO + 1;
  localparam int PRE_W = D_PRE_HI - D_PRE_LO + 1;
  localparam int CNT_W = ACT_W;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_RECOV  = 2'd3
  } tmg_state_e;

  typedef struct packed {
    logic [ACT_W-1:0]   act;
    logic [INACT_W-1:0] inact;
    logic [PRE_W-1:0]   pre;
    logic               blocked;
  } cyc_param_t;

endpackage

// File: rtl/ide_tmg_regfile.sv
module ide_tmg_regfile
  import ide_tmg_pkg::*;
#(
  parameter int NUM_DEV = 4,
  localparam int DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic              load_en,
  input  logic [DEV_W-1:0]  load_dev,
  input  logic [WORD_W-1:0] load_word,
  input  logic [DEV_W-1:0]  cfg_sel,
  output logic [WORD_W-1:0] cfg_word,
  input  logic [DEV_W-1:0]  use_dev,
  output logic [WORD_W-1:0] use_word
);

  logic [NUM_DEV-1:0][WORD_W-1:0] mem;
  logic              pend_v;
  logic [DEV_W-1:0]  pend_dev;
  logic [WORD_W-1:0] pend_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem      <= '0;
      pend_v   <= 1'b0;
      pend_dev <= '0;
      pend_word <= '0;
    end else if (busy) begin
      if (load_en) begin
        pend_v    <= 1'b1;
        pend_dev  <= load_dev;
        pend_word <= load_word;
      end
    end else begin
      if (pend_v) begin
        mem[pend_dev] <= pend_word;
        pend_v <= 1'b0;
      end
      if (load_en) begin
        mem[load_dev] <= load_word;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_word <= '0;
    else     cfg_word <= mem[cfg_sel];
  end

  // word a newly accepted cycle runs with: a parked word not yet committed wins
  always_comb begin
    if (pend_v && (pend_dev == use_dev)) use_word = pend_word;
    else                                 use_word = mem[use_dev];
  end

  // R10: no stored word changes while a cycle is running
  a_r10_hold_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(mem));

  // R1: stored words come out of reset cleared
  a_r1_clear_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> (mem == '0) && !pend_v);

endmodule

// File: rtl/ide_tmg_seq.sv
module ide_tmg_seq
  import ide_tmg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic       req_write,
  input  cyc_param_t prm,
  output logic       busy,
  output logic       rd_n,
  output logic       wr_n,
  output logic       done
);

  tmg_state_e         state;
  logic [CNT_W-1:0]   cnt;
  logic [INACT_W-1:0] inact_q;
  logic [ACT_W-1:0]   act_q;
  logic               wr_q;

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      inact_q <= '0;
      act_q   <= '0;
      wr_q    <= 1'b0;
      rd_n    <= 1'b1;
      wr_n    <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid && !prm.blocked) begin
            act_q   <= prm.act;
            inact_q <= prm.inact;
            wr_q    <= req_write;
            if (prm.pre != '0) begin
              state <= ST_SETUP;
              cnt   <= CNT_W'(prm.pre - 1'b1);
            end else begin
              state <= ST_ACTIVE;
              cnt   <= prm.act;
              rd_n  <= req_write;
              wr_n  <= !req_write;
            end
          end
        end
        ST_SETUP: begin
          if (cnt == '0) begin
            state <= ST_ACTIVE;
            cnt   <= act_q;
            rd_n  <= wr_q;
            wr_n  <= !wr_q;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_ACTIVE: begin
          if (cnt == '0) begin
            state <= ST_RECOV;
            cnt   <= CNT_W'(inact_q);
            rd_n  <= 1'b1;
            wr_n  <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_RECOV: begin
          if (cnt == '0) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: the two strobes are never low together
  a_r7_one_strobe: assert property (@(posedge clk) disable iff (rst)
    rd_n || wr_n);

  // R8: done lasts one clock
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: done only comes with both strobes released
  a_r8_done_released: assert property (@(posedge clk) disable iff (rst)
    done |-> (rd_n && wr_n));

  // R3: recovery is at least one clock, so done never follows a strobe release directly
  a_r3_recovery_min: assert property (@(posedge clk) disable iff (rst)
    ($rose(rd_n) || $rose(wr_n)) |-> !done);

  // R12: while a strobe is low the generator stays busy
  a_r12_busy_in_strobe: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !wr_n) |-> busy);

endmodule

// File: rtl/ide_strobe_timer.sv
module ide_strobe_timer
  import ide_tmg_pkg::*;
#(
  parameter int NUM_DEV = 4,
  localparam int DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [DEV_W-1:0]  load_dev,
  input  logic [WORD_W-1:0] load_word,
  input  logic [DEV_W-1:0]  cfg_sel,
  output logic [WORD_W-1:0] cfg_word,
  input  logic              req_valid,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic              req_write,
  input  logic              req_cmd,
  input  logic              req_first,
  output logic              rd_strobe_n,
  output logic              wr_strobe_n,
  output logic              cycle_done
);

  logic              busy;
  logic [WORD_W-1:0] use_word;
  cyc_param_t        prm;
  logic              unused_word_bits;

  ide_tmg_regfile #(.NUM_DEV(NUM_DEV)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .load_en   (load_en),
    .load_dev  (load_dev),
    .load_word (load_word),
    .cfg_sel   (cfg_sel),
    .cfg_word  (cfg_word),
    .use_dev   (req_dev),
    .use_word  (use_word)
  );

  // select the command or data fields of the word for this request
  always_comb begin
    if (req_cmd) begin
      prm.act   = use_word[C_ACT_HI:C_ACT_LO];
      prm.inact = use_word[C_INACT_HI:C_INACT_LO];
      prm.pre   = req_first ? use_word[C_PRE_HI:C_PRE_LO] : '0;
      prm.blocked = 1'b0;
    end else begin
      prm.act   = use_word[D_ACT_HI:D_ACT_LO];
      prm.inact = use_word[D_INACT_HI:D_INACT_LO];
      prm.pre   = req_first ? use_word[D_PRE_HI:D_PRE_LO] : '0;
      prm.blocked = use_word[UDMA_EN_BIT];
    end
  end

  // stored for readback only
  assign unused_word_bits = ^{use_word[31:29], use_word[21:18]};

  ide_tmg_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .prm       (prm),
    .busy      (busy),
    .rd_n      (rd_strobe_n),
    .wr_n      (wr_strobe_n),
    .done      (cycle_done)
  );

  // R11: a data request to a device in ultra-DMA mode never starts a cycle
  a_r11_udma_blocks: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_valid && !req_cmd && use_word[UDMA_EN_BIT]) |=> !busy);

endmodule

// File: tb/ide_strobe_timer_bench.sv
module ide_strobe_timer_bench;

  localparam int DW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load_en = 1'b0;
  logic [DW-1:0] load_dev = '0;
  logic [31:0] load_word = '0;
  logic [DW-1:0] cfg_sel = '0;
  logic [31:0] cfg_word;
  logic req_valid = 1'b0;
  logic [DW-1:0] req_dev = '0;
  logic req_write = 1'b0;
  logic req_cmd = 1'b0;
  logic req_first = 1'b0;
  logic rd_strobe_n, wr_strobe_n, cycle_done;

  always #10 clk = ~clk;

  ide_strobe_timer #(.NUM_DEV(4)) u_ide_strobe_timer (
    .clk(clk), .rst(rst), .load_en(load_en), .load_dev(load_dev),
    .load_word(load_word), .cfg_sel(cfg_sel), .cfg_word(cfg_word),
    .req_valid(req_valid), .req_dev(req_dev), .req_write(req_write),
    .req_cmd(req_cmd), .req_first(req_first), .rd_strobe_n(rd_strobe_n),
    .wr_strobe_n(wr_strobe_n), .cycle_done(cycle_done)
  );

  typedef struct {
    int    done_at;
    int    rd_low;
    int    wr_low;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit start_flag = 1'b0;
  bit tracking = 1'b0;
  int s_cnt, rd_cnt, wr_cnt;
  bit check_quiet = 1'b0;
  bit prev_done = 1'b0;

  function automatic logic [31:0] mk(int di, int da, int ci, int ca, int dp,
                                     int cp, int ucode, int ctl);
    logic [31:0] w;
    w = '0;
    w[3:0] = di[3:0];   w[8:4] = da[4:0];
    w[12:9] = ci[3:0];  w[17:13] = ca[4:0];
    w[21:18] = ucode[3:0];
    w[24:22] = dp[2:0]; w[27:25] = cp[2:0];
    w[31:28] = ctl[3:0];
    return w;
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, expv, expv);
    end
  endtask

  // monitor: measures each cycle and compares against the queued expectation
  initial begin
    forever begin
      @(negedge clk); #1;
      if (start_flag) begin
        start_flag = 1'b0; tracking = 1'b1;
        s_cnt = 0; rd_cnt = 0; wr_cnt = 0;
      end else if (tracking) s_cnt++;
      if (prev_done) chk(cycle_done == 1'b0, "R8 done width", cycle_done, 0);
      prev_done = cycle_done;
      if (tracking) begin
        if (!rd_strobe_n) rd_cnt++;
        if (!wr_strobe_n) wr_cnt++;
      end
      if (check_quiet)
        chk(rd_strobe_n && wr_strobe_n && !cycle_done, "R11/R12 quiet bus",
            {rd_strobe_n, wr_strobe_n, cycle_done}, 3'b110);
      if (cycle_done) begin
        if (exp_q.size() == 0 || !tracking) begin
          chk(1'b0, "R12 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(s_cnt == e.done_at, {e.tag, " done clock"}, s_cnt, e.done_at);
          chk(rd_cnt == e.rd_low, {e.tag, " read low clocks"}, rd_cnt, e.rd_low);
          chk(wr_cnt == e.wr_low, {e.tag, " write low clocks"}, wr_cnt, e.wr_low);
          tracking = 1'b0;
        end
      end
    end
  end

  task automatic load(int dev, logic [31:0] w);
    @(negedge clk);
    load_en = 1'b1; load_dev = dev[DW-1:0]; load_word = w;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  // issue one cycle; expected values come from the requirement formulas
  task automatic issue(int dev, bit wr, bit cmd, bit first, logic [31:0] w, string tag);
    exp_t e;
    int act, inact, pre;
    act   = cmd ? int'(w[17:13]) : int'(w[8:4]);
    inact = cmd ? int'(w[12:9])  : int'(w[3:0]);
    pre   = first ? (cmd ? int'(w[27:25]) : int'(w[24:22])) : 0;
    e.done_at = pre + act + inact + 2;
    e.rd_low  = wr ? 0 : act + 1;
    e.wr_low  = wr ? act + 1 : 0;
    e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b1; req_dev = dev[DW-1:0]; req_write = wr;
    req_cmd = cmd; req_first = first;
    @(negedge clk);
    req_valid = 1'b0;
    start_flag = 1'b1;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0 || tracking || start_flag) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic poke_ignored(int dev, bit wr, bit cmd);
    @(negedge clk);
    req_valid = 1'b1; req_dev = dev[DW-1:0]; req_write = wr; req_cmd = cmd; req_first = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check_quiet = 1'b1;
    repeat (16) @(negedge clk);
    check_quiet = 1'b0;
  endtask

  task automatic read_cfg(int dev, logic [31:0] expv, string tag);
    @(negedge clk);
    cfg_sel = dev[DW-1:0];
    @(negedge clk); #2;
    chk(cfg_word == expv, tag, cfg_word, expv);
  endtask

  logic [31:0] wa, wb, wc, wu;

  initial begin
    wa = mk(2, 3, 1, 4, 2, 3, 4'hA, 4'b1010);
    wb = mk(5, 1, 3, 6, 1, 0, 4'h3, 4'b0000);
    wc = mk(0, 0, 0, 0, 7, 7, 4'hF, 4'b0100);
    wu = mk(1, 2, 2, 3, 1, 2, 4'h6, 4'b0001);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #2;
    // R1
    chk(rd_strobe_n && wr_strobe_n && !cycle_done, "R1 reset outputs",
        {rd_strobe_n, wr_strobe_n, cycle_done}, 3'b110);
    read_cfg(2, 32'h0, "R1 reset word");

    load(0, wa); load(1, wb); load(2, wc); load(3, wu);
    // R9 full-word readback including bits 21:18 and control bits
    read_cfg(0, wa, "R9 readback dev0");
    read_cfg(3, wu, "R9 readback dev3");
    read_cfg(1, wb, "R13 readback dev1");

    // R2 R3 R7: plain data read and write, no setup
    issue(0, 1'b0, 1'b0, 1'b0, wa, "R2 data read"); wait_idle();
    issue(0, 1'b1, 1'b0, 1'b0, wa, "R7 data write"); wait_idle();
    // R5: first data cycle gets setup delay
    issue(0, 1'b0, 1'b0, 1'b1, wa, "R5 first data read"); wait_idle();
    // R4 R6: command cycles
    issue(0, 1'b1, 1'b1, 1'b0, wa, "R4 cmd write"); wait_idle();
    issue(0, 1'b0, 1'b1, 1'b1, wa, "R6 first cmd read"); wait_idle();
    // R13: other devices with their own words; minimum fields
    issue(1, 1'b1, 1'b0, 1'b1, wb, "R13 dev1 first write"); wait_idle();
    issue(2, 1'b0, 1'b0, 1'b0, wc, "R3 minimum data read"); wait_idle();
    issue(2, 1'b1, 1'b1, 1'b1, wc, "R6 max cmd setup"); wait_idle();

    // R11: ultra-DMA device ignores data requests, still runs command cycles
    poke_ignored(3, 1'b0, 1'b0);
    issue(3, 1'b0, 1'b1, 1'b1, wu, "R11 cmd on udma dev"); wait_idle();

    // R12: second request during a cycle is dropped
    issue(1, 1'b0, 1'b0, 1'b0, wb, "R12 first of overlap");
    @(negedge clk);
    req_valid = 1'b1; req_dev = 0; req_write = 1'b1; req_cmd = 1'b0; req_first = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    check_quiet = 1'b1;
    repeat (16) @(negedge clk);
    check_quiet = 1'b0;

    // R10: load during a cycle is deferred
    issue(0, 1'b0, 1'b0, 1'b0, wa, "R10 cycle with old word");
    @(negedge clk);
    cfg_sel = 0; load_en = 1'b1; load_dev = 0; load_word = wb;
    @(negedge clk);
    load_en = 1'b0;
    @(negedge clk); #2;
    chk(cfg_word == wa, "R10 readback old while busy", cfg_word, wa);
    wait_idle();
    read_cfg(0, wb, "R10 readback new after idle");
    issue(0, 1'b1, 1'b0, 1'b1, wb, "R10 cycle with new word"); wait_idle();

    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule